// File: doc/BRIEF.md
# Sound-Decoder Control Slave (I2C)

This block is the serial control port of a two-carrier TV sound decoder. A host microcontroller writes three-byte frames over a two-wire I2C bus (device address, function byte, data byte) to set the audio output mode, the mute state, a test switch, the free-run selection of the carrier loop and the stereo separation trim. The same device address with the read bit set returns the identification state seen by the pilot detector (stereo or bilingual), coded together with its inverse so that the host can detect a corrupted transfer.

The bus lines are sampled by the block's own clock through two-flop synchronisers. The block pulls SDA low through an open-drain enable and never stretches the clock. The decoded register fields are plain level outputs for the audio matrix. There is no streaming data path, so the block has no valid/ready handshake. Every pin is a plain control or status level.

Top module: `snd_ctl_i2c`

## Requirements
- R1: The 7-bit device address is 1000010 (write 84h, read 85h) when `addr_sel` is 1, and 1000011 (write 86h, read 87h) when `addr_sel` is 0. On any other address the block does not acknowledge, drives nothing for the rest of the frame and changes no field.
- R2: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. A START restarts frame reception at any point, and an unfinished frame changes nothing.
- R3: A write frame is the address byte with bit 0 = 0, a function byte and a data byte, all MSB first. The block acknowledges each byte by pulling SDA low for the ninth clock. The addressed field is updated when the data byte completes, together with its acknowledge.
- R4: The function is chosen by function-byte bits [7:5]: 000 mode, 001 mute, 010 test, 011 free-run, 100 separation. One frame updates at most one field.
- R5: Mode data bits [7:6] drive `audio_mode`: 00 mono, 01 stereo, 10 bilingual, 11 sub. Data bits [5:0] are ignored.
- R6: Mute data bit 7 drives `mute_on`: 0 off, 1 on.
- R7: Separation data bits [7:3] drive `sep_adj`: 00000 minimum, 10000 typical, 11111 maximum.
- R8: Test data bit 7 drives `test_on`. Free-run data bits [7:6] drive `freerun_sel`.
- R9: Function codes 101, 110 and 111 are still acknowledged (address, function and data bytes), but they change no field.
- R10: In a read frame the block acknowledges the second byte and ignores it, then sends a third byte {BI, ST, ~BI, ~ST, 0000}, with BI = `id_stat[1]` and ST = `id_stat[0]`. Mono gives 30h, stereo 60h, bilingual 90h.
- R11: After reset every field is zero (mono, mute off, test off, free-run 00, separation 00000) and SDA is released.
- R12: SDA is sampled on SCL rising edges. The block changes its SDA drive only while SCL is low.
- R13: There is no auto-increment. A byte after the data byte of a write frame is not acknowledged and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel | input | 1 | 1 selects address 1000010, 0 selects 1000011 |
| id_stat | input | 2 | Pilot ID state: bit 1 bilingual, bit 0 stereo |
| audio_mode | output | 2 | Matrix mode: 00 mono, 01 stereo, 10 bilingual, 11 sub |
| mute_on | output | 1 | Audio mute |
| test_on | output | 1 | Test switch |
| freerun_sel | output | 2 | Carrier loop free-run selection |
| sep_adj | output | 5 | Separation trim |

## Verification
The properties assume that the bus keeps each SCL level for several block clocks, longer than the synchroniser latency. They also assume a master that never creates a START or STOP while the slave holds SDA low. Under these assumptions, a drive change observed on the raw `scl_i` always falls in a low phase. The bench master holds each quarter bit for eight clocks, changes SDA only while SCL is low (except for START and STOP), and releases SDA whenever the slave is due to drive it. Field changes are expected only together with an asserted acknowledge, and at most one field changes per frame.

// File: rtl/snd_ctl_pkg.sv
package snd_ctl_pkg;

  // Function codes carried in the top three bits of the function byte
  localparam logic [2:0] FN_MODE    = 3'b000;
  localparam logic [2:0] FN_MUTE    = 3'b001;
  localparam logic [2:0] FN_TEST    = 3'b010;
  localparam logic [2:0] FN_FREERUN = 3'b011;
  localparam logic [2:0] FN_SEP     = 3'b100;

  // Frame position of the byte engine
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_FUNC,
    PH_DATA,
    PH_DONE
  } phase_e;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              q_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q_d <= RST_VAL;
    else        q_d <= chain[STAGES-1];

  assign q    = chain[STAGES-1];
  assign rise = q & ~q_d;
  assign fall = ~q & q_d;
endmodule

// File: rtl/i2c_frame_engine.sv
module i2c_frame_engine
  import snd_ctl_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl,
  input  logic          sda,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_rise,
  input  logic          sda_fall,
  input  logic [AW-1:0] dev_addr,
  input  logic [DW-1:0] rd_byte,
  output logic          sda_oe,
  output logic          wr_stb,
  output logic [DW-1:0] wr_func,
  output logic [DW-1:0] wr_data
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] BITS = CW'(DW);

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic          ackph;
  logic          rnw;
  logic [DW-1:0] shreg;
  logic [DW-1:0] func_q;
  logic [DW-1:0] txsh;

  wire start_c = scl & sda_fall;
  wire stop_c  = scl & sda_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      ackph  <= 1'b0;
      rnw    <= 1'b0;
      shreg  <= '0;
      func_q <= '0;
      txsh   <= '0;
      sda_oe <= 1'b0;
      wr_stb <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (start_c) begin
        phase  <= PH_ADDR;
        cnt    <= '0;
        ackph  <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        phase  <= PH_IDLE;
        cnt    <= '0;
        ackph  <= 1'b0;
        sda_oe <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise && !ackph && cnt < BITS) begin
          shreg <= {shreg[DW-2:0], sda};
          cnt   <= cnt + 1'b1;
        end
        if (scl_fall) begin
          if (ackph) begin
            // end of the acknowledge clock: release and advance
            ackph  <= 1'b0;
            cnt    <= '0;
            sda_oe <= 1'b0;
            unique case (phase)
              PH_ADDR: phase <= PH_FUNC;
              PH_FUNC: begin
                phase <= PH_DATA;
                if (rnw) begin
                  txsh   <= rd_byte;
                  sda_oe <= ~rd_byte[DW-1];
                end
              end
              default: phase <= PH_DONE;
            endcase
          end else if (cnt == BITS) begin
            unique case (phase)
              PH_ADDR: begin
                if (shreg[DW-1:1] == dev_addr) begin
                  ackph  <= 1'b1;
                  sda_oe <= 1'b1;
                  rnw    <= shreg[0];
                end else begin
                  phase <= PH_IDLE;
                end
              end
              PH_FUNC: begin
                ackph  <= 1'b1;
                sda_oe <= 1'b1;
                func_q <= shreg;
              end
              PH_DATA: begin
                ackph <= 1'b1;
                if (rnw) begin
                  sda_oe <= 1'b0;
                end else begin
                  sda_oe <= 1'b1;
                  wr_stb <= 1'b1;
                end
              end
              default: phase <= PH_IDLE;
            endcase
          end else if (phase == PH_DATA && rnw && cnt != '0) begin
            txsh   <= {txsh[DW-2:0], 1'b0};
            sda_oe <= ~txsh[DW-2];
          end
        end
      end
    end
  end

  assign wr_func = func_q;
  assign wr_data = shreg;
endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
  import snd_ctl_pkg::*;
#(
  parameter int DW     = 8,
  parameter int MODE_W = 2,
  parameter int FR_W   = 2,
  parameter int SEP_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [DW-1:0]    wr_func,
  input  logic [DW-1:0]    wr_data,
  output logic [MODE_W-1:0] audio_mode,
  output logic             mute_on,
  output logic             test_on,
  output logic [FR_W-1:0]  freerun_sel,
  output logic [SEP_W-1:0] sep_adj
);
  wire [2:0] code = wr_func[DW-1 -: 3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      audio_mode  <= '0;
      mute_on     <= 1'b0;
      test_on     <= 1'b0;
      freerun_sel <= '0;
      sep_adj     <= '0;
    end else if (wr_stb) begin
      case (code)
        FN_MODE:    audio_mode  <= wr_data[DW-1 -: MODE_W];
        FN_MUTE:    mute_on     <= wr_data[DW-1];
        FN_TEST:    test_on     <= wr_data[DW-1];
        FN_FREERUN: freerun_sel <= wr_data[DW-1 -: FR_W];
        FN_SEP:     sep_adj     <= wr_data[DW-1 -: SEP_W];
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/snd_ctl_i2c.sv
module snd_ctl_i2c #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_HI     = 6'b100001,
  parameter int         SEP_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic             addr_sel,
  input  logic [1:0]       id_stat,
  output logic [1:0]       audio_mode,
  output logic             mute_on,
  output logic             test_on,
  output logic [1:0]       freerun_sel,
  output logic [SEP_W-1:0] sep_adj
);
  localparam int DW = 8;
  localparam int AW = 7;

  logic scl_s, scl_r, scl_f;
  logic sda_s, sda_r, sda_f;
  logic          wr_stb;
  logic [DW-1:0] wr_func, wr_data;

  line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s), .rise(scl_r), .fall(scl_f));

  line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s), .rise(sda_r), .fall(sda_f));

  wire [AW-1:0] dev_addr = {ADDR_HI, ~addr_sel};
  wire [DW-1:0] rd_byte  = {id_stat[1], id_stat[0], ~id_stat[1], ~id_stat[0], 4'b0000};

  i2c_frame_engine #(.AW(AW), .DW(DW)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .scl(scl_s), .sda(sda_s),
    .scl_rise(scl_r), .scl_fall(scl_f),
    .sda_rise(sda_r), .sda_fall(sda_f),
    .dev_addr(dev_addr), .rd_byte(rd_byte),
    .sda_oe(sda_oe), .wr_stb(wr_stb),
    .wr_func(wr_func), .wr_data(wr_data));

  ctl_regs #(.DW(DW), .MODE_W(2), .FR_W(2), .SEP_W(SEP_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_stb), .wr_func(wr_func), .wr_data(wr_data),
    .audio_mode(audio_mode), .mute_on(mute_on), .test_on(test_on),
    .freerun_sel(freerun_sel), .sep_adj(sep_adj));
endmodule

// File: rtl/snd_ctl_i2c_chk.sv
module snd_ctl_i2c_chk #(
  parameter int SEP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_oe,
  input logic [1:0]       audio_mode,
  input logic             mute_on,
  input logic             test_on,
  input logic [1:0]       freerun_sel,
  input logic [SEP_W-1:0] sep_adj
);
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i); // R12

  AST_MODE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(audio_mode) |-> sda_oe); // R3

  AST_FIELDS_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({mute_on, test_on, freerun_sel, sep_adj}) |-> sda_oe); // R3

  AST_MODE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(audio_mode) |-> $stable({mute_on, test_on, freerun_sel, sep_adj})); // R4

  AST_MUTE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mute_on) |-> ($stable(audio_mode) && $stable(sep_adj) && $stable(test_on))); // R4
endmodule

bind snd_ctl_i2c snd_ctl_i2c_chk #(.SEP_W(SEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .audio_mode(audio_mode), .mute_on(mute_on), .test_on(test_on),
  .freerun_sel(freerun_sel), .sep_adj(sep_adj));

// File: tb/snd_ctl_i2c_bench.sv
module snd_ctl_i2c_bench;
  localparam int Q  = 8;
  localparam int NV = 15;

  // {sel, addr, func, data, exp_ack, mode, mute, test, freerun, sep}
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 8'h84, 8'h00, 8'h40, 1'b1, 2'b01, 1'b0, 1'b0, 2'b00, 5'd0},
    {1'b1, 8'h84, 8'h00, 8'h80, 1'b1, 2'b10, 1'b0, 1'b0, 2'b00, 5'd0},
    {1'b1, 8'h84, 8'h20, 8'h80, 1'b1, 2'b10, 1'b1, 1'b0, 2'b00, 5'd0},
    {1'b1, 8'h84, 8'hA0, 8'h00, 1'b1, 2'b10, 1'b1, 1'b0, 2'b00, 5'd0},
    {1'b1, 8'h84, 8'h80, 8'hF8, 1'b1, 2'b10, 1'b1, 1'b0, 2'b00, 5'd31},
    {1'b1, 8'h84, 8'h80, 8'h80, 1'b1, 2'b10, 1'b1, 1'b0, 2'b00, 5'd16},
    {1'b1, 8'h86, 8'h00, 8'hC0, 1'b0, 2'b10, 1'b1, 1'b0, 2'b00, 5'd16},
    {1'b0, 8'h86, 8'h00, 8'hC0, 1'b1, 2'b11, 1'b1, 1'b0, 2'b00, 5'd16},
    {1'b0, 8'h84, 8'h20, 8'h00, 1'b0, 2'b11, 1'b1, 1'b0, 2'b00, 5'd16},
    {1'b1, 8'h84, 8'h60, 8'hC0, 1'b1, 2'b11, 1'b1, 1'b0, 2'b11, 5'd16},
    {1'b1, 8'h84, 8'h40, 8'h80, 1'b1, 2'b11, 1'b1, 1'b1, 2'b11, 5'd16},
    {1'b1, 8'h84, 8'h20, 8'h00, 1'b1, 2'b11, 1'b0, 1'b1, 2'b11, 5'd16},
    {1'b1, 8'h84, 8'h00, 8'h3F, 1'b1, 2'b00, 1'b0, 1'b1, 2'b11, 5'd16},
    {1'b1, 8'h84, 8'hE0, 8'hFF, 1'b1, 2'b00, 1'b0, 1'b1, 2'b11, 5'd16},
    {1'b1, 8'h84, 8'hC0, 8'h40, 1'b1, 2'b00, 1'b0, 1'b1, 2'b11, 5'd16}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mst_scl = 1'b1;
  logic mst_sda = 1'b1;
  logic addr_sel = 1'b1;
  logic [1:0] id_stat = 2'b00;
  logic sda_oe;
  logic [1:0] audio_mode;
  logic mute_on, test_on;
  logic [1:0] freerun_sel;
  logic [4:0] sep_adj;
  wire sda_bus = mst_sda & ~sda_oe;

  int n_chk = 0;
  int n_bad = 0;
  int scl_hi_drive = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  snd_ctl_i2c u_snd_ctl_i2c (
    .clk(clk), .rst_n(rst_n), .scl_i(mst_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .id_stat(id_stat), .audio_mode(audio_mode),
    .mute_on(mute_on), .test_on(test_on), .freerun_sel(freerun_sel), .sep_adj(sep_adj));

  // R12: the slave may change its drive only while SCL is low
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_prev && mst_scl) scl_hi_drive++;
    oe_prev <= sda_oe;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    mst_sda = 1'b1; waitq(1);
    mst_scl = 1'b1; waitq(1);
    mst_sda = 1'b0; waitq(1);
    mst_scl = 1'b0; waitq(1);
  endtask

  task automatic bus_stop();
    mst_sda = 1'b0; waitq(1);
    mst_scl = 1'b1; waitq(1);
    mst_sda = 1'b1; waitq(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mst_sda = b[i]; waitq(1);
      mst_scl = 1'b1; waitq(2);
      mst_scl = 1'b0; waitq(1);
    end
    mst_sda = 1'b1; waitq(1);
    mst_scl = 1'b1; waitq(1);
    ack = ~sda_bus; waitq(1);
    mst_scl = 1'b0; waitq(1);
  endtask

  task automatic read_byte(output logic [7:0] d);
    mst_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitq(1);
      mst_scl = 1'b1; waitq(1);
      d[i] = sda_bus; waitq(1);
      mst_scl = 1'b0;
    end
    waitq(1);
    mst_scl = 1'b1; waitq(2);
    mst_scl = 1'b0; waitq(1);
  endtask

  task automatic check_regs(input string req, input logic [10:0] exp);
    check(req, {21'd0, audio_mode, mute_on, test_on, freerun_sel, sep_adj}, {21'd0, exp});
  endtask

  task automatic read_frame(input logic [7:0] addr, output logic a0, output logic [7:0] d);
    logic a1;
    bus_start();
    send_byte(addr, a0);
    send_byte(8'h00, a1);
    read_byte(d);
    bus_stop();
  endtask

  initial begin
    logic a0, a1, a2, a3;
    logic [7:0] rd;
    repeat (5) @(negedge clk);
    check_regs("R11 reset fields", 11'd0);
    check("R11 reset sda", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1;
    waitq(2);

    for (int v = 0; v < NV; v++) begin
      addr_sel = VEC[v][36];
      bus_start();
      send_byte(VEC[v][35:28], a0);
      send_byte(VEC[v][27:20], a1);
      send_byte(VEC[v][19:12], a2);
      bus_stop();
      waitq(1);
      check($sformatf("R1 ack vec %0d", v), {31'd0, a0}, {31'd0, VEC[v][11]});
      if (VEC[v][11]) check($sformatf("R3 R9 data ack vec %0d", v), {30'd0, a1, a2}, 32'd3);
      check_regs($sformatf("R4 R5 R6 R7 R8 R9 fields vec %0d", v), VEC[v][10:0]);
    end
    addr_sel = 1'b1;

    // R10 read frames
    id_stat = 2'b00; read_frame(8'h85, a0, rd);
    check("R10 read ack", {31'd0, a0}, 32'd1);
    check("R10 mono", {24'd0, rd}, 32'h30);
    id_stat = 2'b01; read_frame(8'h85, a0, rd);
    check("R10 stereo", {24'd0, rd}, 32'h60);
    id_stat = 2'b10; read_frame(8'h85, a0, rd);
    check("R10 bilingual", {24'd0, rd}, 32'h90);
    id_stat = 2'b11; read_frame(8'h85, a0, rd);
    check("R10 both set", {24'd0, rd}, 32'hC0);
    check_regs("R10 read leaves fields", {2'b00, 1'b0, 1'b1, 2'b11, 5'd16});
    addr_sel = 1'b0; read_frame(8'h87, a0, rd);
    check("R1 read sel0 stereo+bi", {24'd0, rd}, 32'hC0);
    addr_sel = 1'b1; read_frame(8'h87, a0, rd);
    check("R1 foreign read nack", {31'd0, a0}, 32'd0);
    check("R1 foreign read idle bus", {24'd0, rd}, 32'hFF);

    // R2 repeated start abandons the first frame
    bus_start(); send_byte(8'h84, a0); send_byte(8'h20, a1);
    bus_start(); send_byte(8'h84, a0); send_byte(8'h00, a1); send_byte(8'h40, a2);
    bus_stop(); waitq(1);
    check_regs("R2 restart", {2'b01, 1'b0, 1'b1, 2'b11, 5'd16});
    bus_start(); send_byte(8'h84, a0); send_byte(8'h20, a1); bus_stop(); waitq(1);
    check_regs("R2 truncated frame", {2'b01, 1'b0, 1'b1, 2'b11, 5'd16});

    // R13 no auto-increment; R7 low step
    bus_start(); send_byte(8'h84, a0); send_byte(8'h80, a1); send_byte(8'h08, a2);
    send_byte(8'hF8, a3); bus_stop(); waitq(1);
    check("R13 extra byte nack", {31'd0, a3}, 32'd0);
    check_regs("R13 R7 extra byte ignored", {2'b01, 1'b0, 1'b1, 2'b11, 5'd1});

    check("R12 drive change with SCL high", scl_hi_drive, 0);

    rst_n = 1'b0; waitq(1);
    check_regs("R11 second reset", 11'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule